// File: doc/BRIEF.md
# Power Sequencing Instruction Engine

This block is a small microcoded controller that steps through a stored program to sequence power rails. Each 32-bit instruction carries a 4-bit opcode in its top nibble. The opcodes cover register-bus writes (plain, masked, single-bit and bit-field forms), loads and stores of four 8-bit storage registers, fixed and register-sourced delays, regulator voltage and mode writes that are issued after a delay, condition waits bounded by a timeout, and programming of a trigger table. The engine fetches from a read-only instruction memory with one cycle of read latency. It acts as master on a simple register bus whose reads return data one cycle after the read strobe.

A set of trigger inputs starts execution. Every trigger input has a programmable start address and can be disabled by a mask bit. The engine sits idle until an enabled trigger is pending. It then runs from that trigger's start address until an END instruction, and returns to idle. Triggers that arrive while a program runs are held and served once the engine is idle again. All delay and timeout counts are in units of an external tick strobe. This lets one timebase pace many engines.

Instruction fields: `[31:28]` opcode, `[27:24]` select (storage register index in bits `[25:24]`, or the regulator, condition or trigger index), `[23:16]` register address, `[15:8]` data, `[7:0]` mask. Immediate delays and timeouts use `[15:0]`.

Top module: `pseq_engine`

## Requirements
- R1: While idle, a pending enabled trigger starts execution at that trigger's table address. When several are pending, the lowest index wins. Triggers that arrive during execution are held and served in index order after END. `busy` is high from the first fetch until END.
- R2: Opcode 0001 issues one bus write with address `[23:16]` and data `[15:8]`.
- R3: Opcodes 0010 (any address) and 0000 (page 0, address bit 7 forced to 0) read the target register and then write `(old & mask) | (data & ~mask)`. Mask bits set to 1 keep their old value.
- R4: Opcode 0000-style page-0 bit write 1101 sets bit `[10:8]` of the target to `[0]`. Window write 1110 places value `[7:0]` into a field of width `[14:12]+1` at bit offset `[10:8]`, clipping bits above bit 7. Both forms read the register first.
- R5: Opcode 1111 loads storage register `[25:24]` with `[15:8]`. Opcode 0110 loads it from a bus read of `[23:16]`. Opcode 0101 writes `(old & mask) | (Rn & ~mask)` to `[23:16]`.
- R6: Opcode 1000 waits `[15:0]` ticks and opcode 1001 waits the value of storage register `[25:24]` in ticks before the next instruction. A zero delay needs no tick.
- R7: Opcodes 0011 and 0100 wait `[7:0]` ticks and then write `[15:8]` to address `VOUT_BASE + sel` or `VCTRL_BASE + sel` respectively.
- R8: Opcode 0111 stalls until condition input `[27:24]` is high or `[15:0]` ticks have elapsed. A true condition has priority over the timeout. A timeout sets the sticky `wait_timeout` flag, and execution continues.
- R9: Opcode 1010 sets the start address of trigger `[27:24]` to the low bits of `[15:0]`. Opcode 1011 loads the trigger mask from the low bits, where 1 disables a trigger. A pulse on a disabled trigger is neither started nor remembered.
- R10: A bus read is a one-cycle `bus_re` pulse, and `bus_rdata` is sampled one cycle later. A write is a one-cycle `bus_we` pulse. The two never coincide, and the bus is quiet while idle.
- R11: Opcode 1100 ends the program and returns the engine to idle. After reset the engine is idle with no bus activity and the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | N_TRIG | Trigger event inputs, one bit per trigger |
| cond_i | input | N_COND | Condition inputs for the wait instruction |
| tick_i | input | 1 | Timebase strobe for delays and timeouts |
| imem_addr | output | PC_W | Instruction memory address (program counter) |
| imem_data | input | 32 | Instruction word, valid one cycle after the address |
| bus_we | output | 1 | Register-bus write strobe |
| bus_re | output | 1 | Register-bus read strobe |
| bus_addr | output | 8 | Register-bus address |
| bus_wdata | output | 8 | Register-bus write data |
| bus_rdata | input | 8 | Register-bus read data, one cycle after `bus_re` |
| busy | output | 1 | High while a program is running |
| wait_timeout | output | 1 | Sticky flag: a wait ended by timeout |

## Verification
The hardest situation to reach from the ports is a trigger arriving while another program is still running, alongside two triggers pending at the same moment. Both must be held and served later in index order. The stimulus gets there by parking a running program on a delay while the tick input is held low. It then pulses further triggers and releases the tick. The order of the register-bus writes then shows the service order. The mask case works the same way: a disabled trigger is pulsed, and a later unmask shows that no run follows.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  localparam int IW     = 32;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam int NSREG  = 4;

  typedef enum logic [3:0] {
    OP_WMP0  = 4'h0,
    OP_WR    = 4'h1,
    OP_WMSK  = 4'h2,
    OP_VOUT  = 4'h3,
    OP_VCTRL = 4'h4,
    OP_WMSR  = 4'h5,
    OP_SRD   = 4'h6,
    OP_WAIT  = 4'h7,
    OP_DLY   = 4'h8,
    OP_DLYR  = 4'h9,
    OP_TSET  = 4'hA,
    OP_TMSK  = 4'hB,
    OP_END   = 4'hC,
    OP_WBIT  = 4'hD,
    OP_WWIN  = 4'hE,
    OP_SIMM  = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_EXEC,
    ST_RD1,
    ST_RD2,
    ST_DELAY,
    ST_WAIT
  } state_e;

endpackage

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tick,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= ld_val;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/pseq_trig.sv
module pseq_trig #(
  parameter int N_TRIG = 4,
  parameter int PC_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              set_en,
  input  logic [3:0]        set_idx,
  input  logic [PC_W-1:0]   set_dest,
  input  logic              mask_en,
  input  logic [N_TRIG-1:0] mask_val,
  input  logic              take,
  output logic              valid,
  output logic [PC_W-1:0]   start_pc
);

  logic [N_TRIG-1:0] pend;
  logic [N_TRIG-1:0] tmask;
  logic [N_TRIG-1:0] avail;
  logic [N_TRIG-1:0] grant;
  logic [PC_W-1:0]   dest [N_TRIG];

  genvar gi;
  generate
    for (gi = 0; gi < N_TRIG; gi++) begin : g_dest
      always_ff @(posedge clk) begin
        if (rst) begin
          dest[gi] <= '0;
        end else if (set_en && (set_idx == 4'(gi))) begin
          dest[gi] <= set_dest;
        end
      end
    end
  endgenerate

  assign avail = pend & ~tmask;
  assign grant = avail & (~avail + 1'b1);
  assign valid = |avail;

  always_comb begin
    start_pc = '0;
    for (int i = 0; i < N_TRIG; i++) begin
      if (grant[i]) start_pc = start_pc | dest[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      tmask <= '0;
    end else begin
      pend <= (pend & ~(take ? grant : '0)) | (trig_i & ~tmask);
      if (mask_en) tmask <= mask_val;
    end
  end

endmodule

// File: rtl/pseq_rmw.sv
module pseq_rmw
  import pseq_pkg::*;
(
  input  op_e         op,
  input  logic [7:0]  dat,
  input  logic [7:0]  msk,
  input  logic [7:0]  sval,
  input  logic [7:0]  old,
  output logic [7:0]  res
);

  logic [7:0] fmask;
  logic [7:0] wmask;

  assign fmask = 8'hFF >> (3'd7 - dat[6:4]);
  assign wmask = fmask << dat[2:0];

  always_comb begin
    res = (old & msk) | (dat & ~msk);
    case (op)
      OP_WMSR: res = (old & msk) | (sval & ~msk);
      OP_WBIT: begin
        res = old;
        res[dat[2:0]] = msk[0];
      end
      OP_WWIN: res = (old & ~wmask) | ((msk & fmask) << dat[2:0]);
      default: ;
    endcase
  end

endmodule

// File: rtl/pseq_engine.sv
module pseq_engine
  import pseq_pkg::*;
#(
  parameter int         PC_W       = 8,
  parameter int         N_TRIG     = 4,
  parameter int         N_COND     = 4,
  parameter int         CNT_W      = 16,
  parameter logic [7:0] VOUT_BASE  = 8'h20,
  parameter logic [7:0] VCTRL_BASE = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [N_COND-1:0] cond_i,
  input  logic              tick_i,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [IW-1:0]     imem_data,
  output logic              bus_we,
  output logic              bus_re,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  output logic              busy,
  output logic              wait_timeout
);

  localparam int CEXT = 16;

  state_e           st;
  logic [PC_W-1:0]  pc;
  logic [IW-1:0]    ir;
  logic [DW-1:0]    sreg [NSREG];
  logic             tmo;

  op_e              op;
  logic [3:0]       f_sel;
  logic [1:0]       f_sidx;
  logic [AW-1:0]    f_addr;
  logic [DW-1:0]    f_data;
  logic [DW-1:0]    f_mask;
  logic [15:0]      f_imm;
  logic [DW-1:0]    sval;
  logic [AW-1:0]    rmw_addr;
  logic [DW-1:0]    rmw_res;
  logic [CEXT-1:0]  cond_ext;
  logic             cond_hit;

  logic             tm_load;
  logic [CNT_W-1:0] tm_val;
  logic             tm_zero;

  logic             tr_valid;
  logic [PC_W-1:0]  tr_pc;
  logic             tr_take;
  logic             tr_set;
  logic             tr_mask;

  assign op       = op_e'(ir[31:28]);
  assign f_sel    = ir[27:24];
  assign f_sidx   = ir[25:24];
  assign f_addr   = ir[23:16];
  assign f_data   = ir[15:8];
  assign f_mask   = ir[7:0];
  assign f_imm    = ir[15:0];
  assign sval     = sreg[f_sidx];
  assign cond_ext = CEXT'(cond_i);
  assign cond_hit = cond_ext[f_sel];

  always_comb begin
    case (op)
      OP_WMP0, OP_WBIT, OP_WWIN: rmw_addr = {1'b0, f_addr[6:0]};
      default:                   rmw_addr = f_addr;
    endcase
  end

  always_comb begin
    tm_load = 1'b0;
    tm_val  = CNT_W'(f_imm);
    if (st == ST_EXEC) begin
      case (op)
        OP_DLY, OP_WAIT:   tm_load = 1'b1;
        OP_DLYR: begin
          tm_load = 1'b1;
          tm_val  = CNT_W'(sval);
        end
        OP_VOUT, OP_VCTRL: begin
          tm_load = 1'b1;
          tm_val  = CNT_W'(f_mask);
        end
        default: ;
      endcase
    end
  end

  assign tr_take = (st == ST_IDLE) && tr_valid;
  assign tr_set  = (st == ST_EXEC) && (op == OP_TSET);
  assign tr_mask = (st == ST_EXEC) && (op == OP_TMSK);

  pseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tm_load),
    .ld_val (tm_val),
    .tick   (tick_i),
    .zero   (tm_zero)
  );

  pseq_trig #(.N_TRIG(N_TRIG), .PC_W(PC_W)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (trig_i),
    .set_en   (tr_set),
    .set_idx  (f_sel),
    .set_dest (f_imm[PC_W-1:0]),
    .mask_en  (tr_mask),
    .mask_val (f_imm[N_TRIG-1:0]),
    .take     (tr_take),
    .valid    (tr_valid),
    .start_pc (tr_pc)
  );

  pseq_rmw u_rmw (
    .op   (op),
    .dat  (f_data),
    .msk  (f_mask),
    .sval (sval),
    .old  (bus_rdata),
    .res  (rmw_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pc        <= '0;
      ir        <= '0;
      tmo       <= 1'b0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      for (int i = 0; i < NSREG; i++) sreg[i] <= '0;
    end else begin
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (tr_valid) begin
            pc <= tr_pc;
            st <= ST_FETCH;
          end
        end
        ST_FETCH: st <= ST_LOAD;
        ST_LOAD: begin
          ir <= imem_data;
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          case (op)
            OP_WR: begin
              bus_we    <= 1'b1;
              bus_addr  <= f_addr;
              bus_wdata <= f_data;
              pc        <= pc + 1'b1;
              st        <= ST_FETCH;
            end
            OP_WMP0, OP_WMSK, OP_WMSR, OP_WBIT, OP_WWIN, OP_SRD: begin
              bus_re   <= 1'b1;
              bus_addr <= rmw_addr;
              st       <= ST_RD1;
            end
            OP_VOUT, OP_VCTRL, OP_DLY, OP_DLYR: st <= ST_DELAY;
            OP_WAIT: st <= ST_WAIT;
            OP_SIMM: begin
              sreg[f_sidx] <= f_data;
              pc           <= pc + 1'b1;
              st           <= ST_FETCH;
            end
            OP_END: st <= ST_IDLE;
            default: begin
              pc <= pc + 1'b1;
              st <= ST_FETCH;
            end
          endcase
        end
        ST_RD1: st <= ST_RD2;
        ST_RD2: begin
          if (op == OP_SRD) begin
            sreg[f_sidx] <= bus_rdata;
          end else begin
            bus_we    <= 1'b1;
            bus_wdata <= rmw_res;
          end
          pc <= pc + 1'b1;
          st <= ST_FETCH;
        end
        ST_DELAY: begin
          if (tm_zero) begin
            if (op == OP_VOUT || op == OP_VCTRL) begin
              bus_we    <= 1'b1;
              bus_addr  <= ((op == OP_VOUT) ? VOUT_BASE : VCTRL_BASE) + {4'b0, f_sel};
              bus_wdata <= f_data;
            end
            pc <= pc + 1'b1;
            st <= ST_FETCH;
          end
        end
        ST_WAIT: begin
          if (cond_hit) begin
            pc <= pc + 1'b1;
            st <= ST_FETCH;
          end else if (tm_zero) begin
            tmo <= 1'b1;
            pc  <= pc + 1'b1;
            st  <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign imem_addr    = pc;
  assign busy         = (st != ST_IDLE);
  assign wait_timeout = tmo;

endmodule

// File: rtl/pseq_checker.sv
module pseq_checker (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic bus_we,
  input logic bus_re,
  input logic wait_timeout
);

  // R10: read and write strobes are exclusive
  p_no_rw_clash_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));

  // R10: an idle engine leaves the bus quiet
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_we && !bus_re));

  // R10: a read strobe lasts one cycle and its data cycle follows while running, without a write
  p_read_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> (!bus_re && !bus_we && busy));

  // R8: the timeout flag never clears on its own
  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    wait_timeout |=> wait_timeout);

  // R8: the timeout flag can only rise while a program runs
  p_tmo_busy_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_timeout) |-> busy);

endmodule

bind pseq_engine pseq_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .bus_we       (bus_we),
  .bus_re       (bus_re),
  .wait_timeout (wait_timeout)
);

// File: tb/sim_pseq_engine.sv
module sim_pseq_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  trig_i = '0;
  logic [3:0]  cond_i = '0;
  logic        tick_i = 1'b0;
  logic [7:0]  imem_addr;
  logic [31:0] imem_data;
  logic        bus_we, bus_re;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        busy, wait_timeout;

  logic [31:0] imem [256];
  logic [7:0]  regs [256];
  logic [7:0]  log_a [64];
  int          wr_cnt;
  logic        clr;
  logic        pl_en;
  logic [7:0]  pl_addr, pl_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pseq_engine u0 (
    .clk(clk), .rst(rst), .trig_i(trig_i), .cond_i(cond_i), .tick_i(tick_i),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .wait_timeout(wait_timeout)
  );

  always @(posedge clk) imem_data <= imem[imem_addr];

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) regs[i] <= 8'h00;
      wr_cnt <= 0;
    end else begin
      if (bus_re) bus_rdata <= regs[bus_addr];
      if (pl_en) regs[pl_addr] <= pl_data;
      if (bus_we) begin
        regs[bus_addr] <= bus_wdata;
        if (wr_cnt < 64) log_a[wr_cnt] <= bus_addr;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] ins(input logic [3:0] op, input logic [3:0] sel,
                                      input logic [7:0] a, input logic [7:0] d,
                                      input logic [7:0] m);
    return {op, sel, a, d, m};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic pulse_trig(input int idx);
    @(negedge clk); trig_i = 4'b0001 << idx;
    @(negedge clk); trig_i = '0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int k = 0; k < 5000 && quiet < 6; k++) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic run0();
    pulse_trig(0);
    wait_idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 idle after reset", busy, 0);
    check("R10 no bus activity after reset", {bus_we, bus_re}, 0);
    check("R11 flag clear after reset", wait_timeout, 0);
  endtask

  task automatic t_write();
    clear_all();
    imem[0] = ins(4'h1, 4'h0, 8'h05, 8'h3C, 8'h00);
    imem[1] = ins(4'h1, 4'h0, 8'h85, 8'h5A, 8'h00);
    imem[2] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    check("R2 plain write low", regs[8'h05], 8'h3C);
    check("R2 plain write high", regs[8'h85], 8'h5A);
    check("R2 exactly two writes", wr_cnt, 2);
    check("R11 idle after END", busy, 0);
  endtask

  task automatic t_masked();
    clear_all();
    preload(8'h12, 8'hF0);
    preload(8'h13, 8'hAA);
    preload(8'h93, 8'h77);
    preload(8'h94, 8'h0F);
    imem[0] = ins(4'h2, 4'h0, 8'h12, 8'h3C, 8'h0F);
    imem[1] = ins(4'h0, 4'h0, 8'h93, 8'h55, 8'hF0);
    imem[2] = ins(4'h2, 4'h0, 8'h94, 8'h00, 8'hFF);
    imem[3] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    check("R3 masked write", regs[8'h12], 8'h30);
    check("R3 page0 masked write target", regs[8'h13], 8'hA5);
    check("R3 page0 leaves high page alone", regs[8'h93], 8'h77);
    check("R3 full mask keeps value", regs[8'h94], 8'h0F);
  endtask

  task automatic t_bitwin();
    clear_all();
    preload(8'h40, 8'h81);
    preload(8'h41, 8'hFF);
    imem[0] = ins(4'hD, 4'h0, 8'h40, 8'h03, 8'h01);
    imem[1] = ins(4'hD, 4'h0, 8'hC0, 8'h07, 8'h00);
    imem[2] = ins(4'hE, 4'h0, 8'hC1, 8'h22, 8'h05);
    imem[3] = ins(4'hE, 4'h0, 8'h42, 8'h36, 8'h0F);
    imem[4] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    check("R4 bit writes", regs[8'h40], 8'h09);
    check("R4 window write", regs[8'h41], 8'hF7);
    check("R4 window clipped at bit 7", regs[8'h42], 8'hC0);
  endtask

  task automatic t_sreg();
    clear_all();
    preload(8'h50, 8'h6D);
    preload(8'h51, 8'hF3);
    preload(8'h52, 8'h11);
    imem[0] = ins(4'h6, 4'h2, 8'h50, 8'h00, 8'h00);
    imem[1] = ins(4'hF, 4'h1, 8'h00, 8'h99, 8'h00);
    imem[2] = ins(4'h5, 4'h2, 8'h51, 8'h00, 8'h0F);
    imem[3] = ins(4'h5, 4'h1, 8'h52, 8'h00, 8'h00);
    imem[4] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    check("R5 read into R2 then masked store", regs[8'h51], 8'h63);
    check("R5 immediate R1 store", regs[8'h52], 8'h99);
  endtask

  task automatic t_delay();
    clear_all();
    imem[0] = ins(4'h8, 4'h0, 8'h00, 8'h00, 8'h03);
    imem[1] = ins(4'h1, 4'h0, 8'h60, 8'h11, 8'h00);
    imem[2] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    pulse_trig(0);
    repeat (30) @(negedge clk);
    check("R6 delay holds without ticks", {busy, regs[8'h60]}, {1'b1, 8'h00});
    pulse_tick(); repeat (4) @(negedge clk);
    pulse_tick(); repeat (10) @(negedge clk);
    check("R6 delay holds after two of three ticks", regs[8'h60], 8'h00);
    pulse_tick();
    wait_idle();
    check("R6 delay released after third tick", regs[8'h60], 8'h11);

    imem[0] = ins(4'hF, 4'h3, 8'h00, 8'h02, 8'h00);
    imem[1] = ins(4'h9, 4'h3, 8'h00, 8'h00, 8'h00);
    imem[2] = ins(4'h1, 4'h0, 8'h61, 8'h22, 8'h00);
    imem[3] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    pulse_trig(0);
    repeat (30) @(negedge clk);
    pulse_tick(); repeat (10) @(negedge clk);
    check("R6 register delay holds after one tick", regs[8'h61], 8'h00);
    pulse_tick();
    wait_idle();
    check("R6 register delay released", regs[8'h61], 8'h22);

    imem[0] = ins(4'h8, 4'h0, 8'h00, 8'h00, 8'h00);
    imem[1] = ins(4'h1, 4'h0, 8'h62, 8'h33, 8'h00);
    imem[2] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    check("R6 zero delay needs no tick", {busy, regs[8'h62]}, {1'b0, 8'h33});
  endtask

  task automatic t_vout();
    clear_all();
    imem[0] = ins(4'h3, 4'h3, 8'h00, 8'h7E, 8'h01);
    imem[1] = ins(4'h4, 4'h1, 8'h00, 8'h02, 8'h00);
    imem[2] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    pulse_trig(0);
    repeat (30) @(negedge clk);
    check("R7 voltage write waits for delay", {busy, regs[8'h23]}, {1'b1, 8'h00});
    pulse_tick();
    wait_idle();
    check("R7 voltage write to base+3", regs[8'h23], 8'h7E);
    check("R7 mode write to base+1", regs[8'h31], 8'h02);
  endtask

  task automatic t_wait();
    clear_all();
    imem[0] = ins(4'h7, 4'h2, 8'h00, 8'h00, 8'h05);
    imem[1] = ins(4'h1, 4'h0, 8'h70, 8'h44, 8'h00);
    imem[2] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    pulse_trig(0);
    repeat (20) @(negedge clk);
    check("R8 wait stalls on false condition", {busy, regs[8'h70]}, {1'b1, 8'h00});
    cond_i = 4'b0100;
    wait_idle();
    check("R8 condition releases wait", regs[8'h70], 8'h44);
    check("R8 no timeout when condition met", wait_timeout, 0);

    cond_i = 4'b0001;
    imem[0] = ins(4'h7, 4'h0, 8'h00, 8'h00, 8'h00);
    imem[1] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    check("R8 condition beats zero timeout", wait_timeout, 0);

    cond_i = 4'b0000;
    imem[0] = ins(4'h7, 4'h1, 8'h00, 8'h00, 8'h02);
    imem[1] = ins(4'h1, 4'h0, 8'h71, 8'h55, 8'h00);
    imem[2] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    pulse_trig(0);
    repeat (20) @(negedge clk);
    pulse_tick(); repeat (4) @(negedge clk);
    pulse_tick();
    wait_idle();
    check("R8 timeout sets flag", wait_timeout, 1);
    check("R8 execution continues after timeout", regs[8'h71], 8'h55);

    imem[0] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    check("R8 flag is sticky", wait_timeout, 1);
  endtask

  task automatic t_trig();
    int seen;
    clear_all();
    imem[0] = ins(4'hA, 4'h1, 8'h00, 8'h00, 8'h40);
    imem[1] = ins(4'hA, 4'h2, 8'h00, 8'h00, 8'h50);
    imem[2] = ins(4'hA, 4'h3, 8'h00, 8'h00, 8'h60);
    imem[3] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    imem[8'h40] = ins(4'h1, 4'h0, 8'h10, 8'hA1, 8'h00);
    imem[8'h41] = ins(4'h8, 4'h0, 8'h00, 8'h00, 8'h01);
    imem[8'h42] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    imem[8'h50] = ins(4'h1, 4'h0, 8'h11, 8'hB2, 8'h00);
    imem[8'h51] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    imem[8'h60] = ins(4'h1, 4'h0, 8'h12, 8'hC3, 8'h00);
    imem[8'h61] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    clear_all();
    @(negedge clk); trig_i = 4'b0110;
    @(negedge clk); trig_i = 4'b0000;
    repeat (30) @(negedge clk);
    check("R1 lowest pending trigger runs first", {busy, regs[8'h10], regs[8'h11]}, {1'b1, 8'hA1, 8'h00});
    pulse_trig(3);
    repeat (5) @(negedge clk);
    pulse_tick();
    wait_idle();
    check("R1 held trigger 2 served", regs[8'h11], 8'hB2);
    check("R1 trigger arriving mid-run served", regs[8'h12], 8'hC3);
    check("R1 service order", {log_a[0], log_a[1], log_a[2]}, {8'h10, 8'h11, 8'h12});

    clear_all();
    imem[0] = ins(4'hB, 4'h0, 8'h00, 8'h00, 8'h08);
    imem[1] = ins(4'hC, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    pulse_trig(3);
    seen = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    check("R9 masked trigger does not start", seen, 0);
    imem[0] = ins(4'hB, 4'h0, 8'h00, 8'h00, 8'h00);
    run0();
    check("R9 masked trigger not remembered", regs[8'h12], 8'h00);
    pulse_trig(3);
    wait_idle();
    check("R9 unmasked trigger runs", regs[8'h12], 8'hC3);
  endtask

  initial begin
    clr = 1'b0; pl_en = 1'b0; pl_addr = '0; pl_data = '0;
    for (int i = 0; i < 256; i++) imem[i] = 32'hC000_0000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write();
    t_masked();
    t_bitwin();
    t_sreg();
    t_delay();
    t_vout();
    t_wait();
    t_trig();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule